// File: doc/BRIEF.md
# Serial-bus register target with pointer auto-advance

This block is an I2C target that lets a host reach a small bank of configuration bytes over two wires. It runs entirely from a fast system clock. SCL and SDA are oversampled, cleaned up, and turned into bit-clock edges and bus START and STOP events. The target answers to a 7-bit address. The upper four bits of that address are fixed, and three strap inputs supply the lower three. After a write address, the first data byte sets an internal control byte. That byte holds a 3-bit register pointer and an auto-advance flag. Every later byte in the transaction is written to the register the pointer selects. Reads return bytes starting at the current pointer.

With auto-advance on, the pointer steps through the bank after each byte and wraps from 7 to 0. One transaction can therefore load or dump every register. Neighbouring logic sees the six configuration bytes as outputs and a one-cycle write strobe with index and data. It supplies a live input byte that is read at index 0.

Top module: `i2c_regs_target`

## Requirements
- R1: After reset the six configuration outputs are 00h, `sda_oe` is 0 and `wr_stb` is 0. The control byte is 00h, so the pointer is 0 and auto-advance is off, and a read transaction first returns `in_port`.
- R2: The block acknowledges the address byte by pulling SDA low during the ninth SCL clock only when bits 7:1 equal binary 1100 followed by `strap[2:0]`. For any other address it neither acknowledges nor acts on the bytes that follow, until the next START.
- R3: Bit 0 of the address byte selects the direction: 0 is a write transaction and 1 is a read transaction.
- R4: The first byte of a write transaction is acknowledged and loads the control byte. Bit 4 is the auto-advance flag and bits 2:0 are the register pointer. That byte writes no register.
- R5: Register indices are: 0 the read-only `in_port`, 1 `rate0_div`, 2 `rate0_duty`, 3 `rate1_div`, 4 `rate1_duty`, 5 `sel_lo`, 6 `sel_hi`, and 7 reads as 00h. Every later written byte is acknowledged. A write to index 1..6 updates that register and pulses `wr_stb` for one cycle with `wr_idx` and `wr_data`. Writes to index 0 or 7 change nothing and raise no strobe.
- R6: With auto-advance set, the pointer increments after each written data byte and after each read byte the host acknowledges, and it wraps from 7 to 0.
- R7: With auto-advance clear, the pointer stays fixed, so every byte of a transaction uses the same register.
- R8: When the host does not acknowledge a read byte, the pointer does not advance. The block keeps SDA released until the next START.
- R9: A repeated START, with no STOP before it, returns the block to address matching.
- R10: A STOP ends any transaction. The pointer and auto-advance flag are kept across transactions and change only through the first byte of a write.
- R11: While `rst_n` is low, all registers and the bus state are held at their reset values and `sda_oe` and `wr_stb` are 0.
- R12: A pulse lasting one system clock on SCL or SDA is ignored. It creates no bit clock, no START and no STOP.
- R13: Bytes are sent most significant bit first. The host's SDA is sampled on SCL rising, and the block changes the SDA it drives only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| strap | input | 3 | Low three address bits |
| in_port | input | 8 | Byte returned at register index 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | 3 | Index of the register written |
| wr_data | output | 8 | Byte written |
| rate0_div | output | 8 | Register 1 |
| rate0_duty | output | 8 | Register 2 |
| rate1_div | output | 8 | Register 3 |
| rate1_duty | output | 8 | Register 4 |
| sel_lo | output | 8 | Register 5 |
| sel_hi | output | 8 | Register 6 |

## Verification
The hardest case to reach from the ports is a pointer at the edge of the map. A read must return the reserved index 7 as 00h and then wrap to index 0, and a NACKed read must leave the pointer where it was. The stimulus first writes a control byte that parks the pointer at 6 and streams bytes across the wrap. It then reads back across the same boundary. NACKed reads are followed by bare read transactions, so that any pointer drift appears in the returned bytes. Single-clock glitches are also injected on SCL during a low phase and on SDA during a high phase, in the middle of a data byte, and the byte must still land intact.

// File: rtl/i2c_regs_target.sv
module i2c_regs_target #(
  parameter logic [3:0] ADDR_HI = 4'b1100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic [7:0] in_port,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [2:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rate0_div,
  output logic [7:0] rate0_duty,
  output logic [7:0] rate1_div,
  output logic [7:0] rate1_duty,
  output logic [7:0] sel_lo,
  output logic [7:0] sel_hi
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_ADDR = 3'd1;
  localparam logic [2:0] ST_WR   = 3'd2;
  localparam logic [2:0] ST_ACK  = 3'd3;
  localparam logic [2:0] ST_RD   = 3'd4;
  localparam logic [2:0] ST_MACK = 3'd5;

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_q, sda_q, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_q <= 1'b1; sda_q <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_q <= (scl_h[0] & scl_h[1]) | (scl_h[0] & scl_h[2]) | (scl_h[1] & scl_h[2]);
      sda_q <= (sda_h[0] & sda_h[1]) | (sda_h[0] & sda_h[2]) | (sda_h[1] & sda_h[2]);
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  wire scl_r = scl_q & ~scl_d;
  wire scl_f = ~scl_q & scl_d;
  wire start = scl_q & scl_d & sda_d & ~sda_q;
  wire stop  = scl_q & scl_d & ~sda_d & sda_q;

  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, first, ai, mack;
  logic [2:0] ptr;
  logic [7:0] cfg [0:7];

  wire  [2:0] nptr   = ai ? ptr + 3'd1 : ptr;
  wire  [7:0] rd_cur = (ptr == 3'd0) ? in_port : (ptr == 3'd7) ? 8'h00 : cfg[ptr];
  wire  [7:0] rd_nxt = (nptr == 3'd0) ? in_port : (nptr == 3'd7) ? 8'h00 : cfg[nptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0;
      rw <= 1'b0; first <= 1'b0; ai <= 1'b0; mack <= 1'b0; ptr <= '0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
      for (int i = 0; i < 8; i++) cfg[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_r) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_f && cnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (sh[7:1] == {ADDR_HI, strap}) begin
                  sda_oe <= 1'b1; rw <= sh[0]; first <= 1'b1; st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1; st <= ST_ACK;
                if (first) begin
                  ai <= sh[4]; ptr <= sh[2:0]; first <= 1'b0;
                end else begin
                  if (ptr != 3'd0 && ptr != 3'd7) begin
                    cfg[ptr] <= sh; wr_stb <= 1'b1; wr_idx <= ptr; wr_data <= sh;
                  end
                  ptr <= nptr;
                end
              end
            end
          end
          ST_ACK: if (scl_f) begin
            cnt <= '0;
            if (rw) begin
              sh <= rd_cur; sda_oe <= ~rd_cur[7]; st <= ST_RD;
            end else begin
              sda_oe <= 1'b0; st <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_r) cnt <= cnt + 4'd1;
            else if (scl_f) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= ST_MACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_r) mack <= ~sda_q;
            else if (scl_f) begin
              if (mack) begin
                ptr <= nptr; sh <= rd_nxt; sda_oe <= ~rd_nxt[7]; cnt <= '0; st <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rate0_div  = cfg[1];
  assign rate0_duty = cfg[2];
  assign rate1_div  = cfg[3];
  assign rate1_duty = cfg[4];
  assign sel_lo     = cfg[5];
  assign sel_hi     = cfg[6];

endmodule

// File: rtl/i2c_regs_target_chk.sv
module i2c_regs_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic [2:0] st,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [2:0] wr_idx
);

  p_drive_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  p_stb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_stb_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx != 3'd0 && wr_idx != 3'd7));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  p_reset_hold_r11: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !wr_stb && st == 3'd0));

endmodule

bind i2c_regs_target i2c_regs_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_q), .st(st),
  .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx)
);

// File: tb/i2c_regs_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regs_target_tb_top;

  localparam int Q = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MYADR = {4'b1100, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] in_port = 8'hA5;
  logic sda_oe, wr_stb;
  logic [2:0] wr_idx;
  logic [7:0] wr_data, r0d, r0p, r1d, r1p, slo, shi;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regs_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap(STRAP),
    .in_port(in_port), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rate0_div(r0d), .rate0_duty(r0p), .rate1_div(r1d),
    .rate1_duty(r1p), .sel_lo(slo), .sel_hi(shi)
  );

  int n_cmp = 0, n_err = 0, oe_bad = 0, oe_seen = 0;
  bit done = 0, glitch = 0;
  logic oe_prev = 1'b0;
  logic [7:0] m [0:7];
  logic [2:0] bptr = '0;
  logic bai = 1'b0;
  logic [10:0] exp_wr [$];
  logic [7:0] exp_rd [$];
  string exp_tag [$];
  logic [7:0] obs_rd [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_wr.size() == 0) chk("R5 unexpected strobe", {21'd0, wr_idx, wr_data}, 32'hFFFF);
      else chk("R5 strobe", {21'd0, wr_idx, wr_data}, {21'd0, exp_wr.pop_front()});
    end
    while (obs_rd.size() > 0) begin
      if (exp_rd.size() == 0) chk("R5 extra read", {24'd0, obs_rd.pop_front()}, 32'hFFFF);
      else chk(exp_tag.pop_front(), {24'd0, obs_rd.pop_front()}, {24'd0, exp_rd.pop_front()});
    end
    if (sda_oe !== oe_prev && scl_m) oe_bad++;
    if (sda_oe) oe_seen++;
    oe_prev = sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        tick(Q/2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q/2);
        scl_m = 1'b1; tick(Q/2); sda_m = ~b[i]; tick(1); sda_m = b[i]; tick(Q/2);
      end else begin
        tick(Q); scl_m = 1'b1; tick(Q);
      end
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2); ack = ~sda_bus; tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q/2); b[i] = sda_bus; tick(Q/2); scl_m = 1'b0;
    end
    sda_m = ~ack_it; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] model_rd(logic [2:0] p);
    return (p == 3'd0) ? in_port : (p == 3'd7) ? 8'h00 : m[p];
  endfunction

  task automatic set_ptr(input logic [7:0] ctrl);
    logic a;
    start_c;
    send_byte({MYADR, 1'b0}, a); chk("R2 address ack", a, 1);
    send_byte(ctrl, a);          chk("R4 control ack", a, 1);
    bptr = ctrl[2:0]; bai = ctrl[4];
  endtask

  task automatic wr_regs(input logic [7:0] ctrl, input int n, input logic [7:0] d [8]);
    logic a;
    set_ptr(ctrl);
    for (int k = 0; k < n; k++) begin
      if (bptr != 3'd0 && bptr != 3'd7) begin
        exp_wr.push_back({bptr, d[k]}); m[bptr] = d[k];
      end
      send_byte(d[k], a); chk("R5 data ack", a, 1);
      if (bai) bptr = bptr + 3'd1;
    end
    stop_c; tick(4);
  endtask

  task automatic rd_regs(input int n, input string tag);
    logic a;
    logic [7:0] b;
    start_c;
    send_byte({MYADR, 1'b1}, a); chk("R3 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      exp_rd.push_back(model_rd(bptr)); exp_tag.push_back(tag);
      recv_byte(k < n - 1, b);
      obs_rd.push_back(b);
      if (k < n - 1 && bai) bptr = bptr + 3'd1;
    end
    tick(6); chk("R8 released after NACK", sda_oe, 0);
    stop_c; tick(4);
  endtask

  task automatic check_outs(string req);
    chk(req, {r0d, r0p, r1d, r1p}, {m[1], m[2], m[3], m[4]});
    chk(req, {16'd0, slo, shi}, {16'd0, m[5], m[6]});
  endtask

  initial begin
    logic a;
    for (int i = 0; i < 8; i++) m[i] = '0;
    tick(5);
    chk("R11 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1; tick(5);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset strobe", wr_stb, 0);
    check_outs("R1 reset registers");
    rd_regs(1, "R1 pointer 0 reads in_port");

    wr_regs(8'h11, 6, '{8'h81, 8'h42, 8'h3C, 8'hC3, 8'h55, 8'hAA, 8'h00, 8'h00});
    check_outs("R6 auto-advance write");
    set_ptr(8'h11);
    rd_regs(6, "R9 R6 repeated-start read");

    wr_regs(8'h16, 3, '{8'h66, 8'h77, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    check_outs("R5 index 0 and 7 ignore writes");
    in_port = 8'h3C;
    set_ptr(8'h16);
    rd_regs(4, "R6 wrap read 6,7,0,1");

    wr_regs(8'h02, 2, '{8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    check_outs("R7 fixed pointer write");
    set_ptr(8'h02);
    rd_regs(3, "R7 fixed pointer read");

    set_ptr(8'h13); stop_c; tick(4);
    rd_regs(1, "R10 pointer kept across STOP");
    rd_regs(1, "R8 NACK keeps pointer");
    rd_regs(2, "R8 ack advances then NACK");
    rd_regs(1, "R8 pointer after NACK");

    oe_seen = 0;
    start_c;
    send_byte({4'b1100, 3'b010, 1'b0}, a); chk("R2 wrong strap no ack", a, 0);
    send_byte(8'h11, a); chk("R2 ignored byte no ack", a, 0);
    send_byte(8'h5A, a);
    stop_c;
    start_c;
    send_byte({4'b1000, STRAP, 1'b0}, a); chk("R2 wrong prefix no ack", a, 0);
    stop_c; tick(4);
    chk("R2 never drove SDA", oe_seen, 0);
    check_outs("R2 registers unchanged");

    glitch = 1;
    wr_regs(8'h15, 1, '{8'hB7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    glitch = 0;
    check_outs("R12 glitch filtered");

    set_ptr(8'h11);
    rst_n = 1'b0; tick(10);
    for (int i = 0; i < 8; i++) m[i] = '0;
    bptr = '0; bai = 1'b0;
    check_outs("R11 reset clears registers");
    chk("R11 sda_oe held", sda_oe, 0);
    rst_n = 1'b1; tick(4);
    send_byte(8'hEE, a); chk("R11 no ack after reset", a, 0);
    stop_c; tick(4);
    rd_regs(1, "R11 pointer back to 0");

    tick(20);
    chk("R5 all strobes seen", exp_wr.size(), 0);
    chk("R13 all reads compared", exp_rd.size(), 0);
    chk("R13 SDA drive change only with SCL low", oe_bad, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_err++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule